// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the current source and destination addresses of one DMA channel and steps them as the channel's transfer engine reports progress. A read-complete strobe moves the source address by its signed per-access offset, and a write-complete strobe does the same for the destination address. An end-of-minor-loop strobe can add a shared signed minor-loop offset to either side; each side has its own enable. An end-of-major-loop strobe adds a per-side final adjustment.

Each side can optionally wrap inside a power-of-two circular window. When wrapping is on, only the low bits of the offset result take the new value. The block also keeps sticky flags for three problems: an address not aligned to the access size, an offset not aligned to the access size, and an access-size code with no meaning. A load strobe starts a new transfer. It writes both start addresses and clears every flag in the same cycle.

Top module: `dma_addr_gen`

## Requirements
- R1: On the clock edge where `load` is high, both addresses take `src_start`/`dst_start` and all six error flags clear; `load` overrides every strobe in that cycle.
- R2: A `rd_done` cycle adds the sign-extended 16-bit `src_off` to the source address; a `wr_done` cycle adds the sign-extended `dst_off` to the destination address; each strobe leaves the other side's address untouched.
- R3: Access-size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 4 = 16 bytes, 5 = 32 bytes; an address is aligned when its low log2(size) bits are zero.
- R4: A modulo code of 0 disables wrapping. A code n from 1 to 31 takes the low n bits of the address from (address + offset) and keeps the upper bits of the previous address.
- R5: A `minor_done` cycle adds the sign-extended `mloff` to the source address when `mloff_src_en` is 1, and to the destination address when `mloff_dst_en` is 1. A disabled side is unchanged. Wrapping is not applied to this addition.
- R6: A `major_done` cycle adds `src_last` to the source address and `dst_last` to the destination address.
- R7: When strobes coincide in one cycle, the order is: per-access offset with wrapping, then the minor-loop offset, then the final adjustment.
- R8: The `*_addr_err` flag of a side sets one edge after that side's address is misaligned to its valid size, and stays set until `load` or reset.
- R9: The `*_off_err` flag of a side sets one edge after that side's offset is misaligned to its valid size, and stays set until `load` or reset.
- R10: Size codes 3, 6 and 7 set that side's `*_cfg_err` flag (sticky) and freeze that side's address against all strobes. The other side is unaffected.
- R11: With no `load`, `rd_done`, `minor_done` or `major_done`, the source address holds. The destination address likewise holds with no `load`, `wr_done`, `minor_done` or `major_done`.
- R12: After reset, both addresses are zero and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write start addresses, clear flags |
| src_start | input | ADDR_W | Source start address |
| dst_start | input | ADDR_W | Destination start address |
| src_off | input | OFF_W | Signed source per-access offset |
| dst_off | input | OFF_W | Signed destination per-access offset |
| src_size | input | 3 | Source access-size code |
| dst_size | input | 3 | Destination access-size code |
| src_mod | input | 5 | Source wrap code (0 = off) |
| dst_mod | input | 5 | Destination wrap code (0 = off) |
| mloff_src_en | input | 1 | Apply minor-loop offset to source |
| mloff_dst_en | input | 1 | Apply minor-loop offset to destination |
| mloff | input | MLOFF_W | Signed minor-loop offset |
| src_last | input | ADDR_W | Source end-of-major adjustment |
| dst_last | input | ADDR_W | Destination end-of-major adjustment |
| rd_done | input | 1 | Source read completed |
| wr_done | input | 1 | Destination write completed |
| minor_done | input | 1 | Minor loop completed |
| major_done | input | 1 | Major loop completed |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| src_addr_err | output | 1 | Sticky source address misalignment |
| src_off_err | output | 1 | Sticky source offset misalignment |
| src_cfg_err | output | 1 | Sticky reserved source size code |
| dst_addr_err | output | 1 | Sticky destination address misalignment |
| dst_off_err | output | 1 | Sticky destination offset misalignment |
| dst_cfg_err | output | 1 | Sticky reserved destination size code |

## Verification
The assertions check the following on every cycle:
- the load takeover and flag clearing;
- address holding when no strobe is present;
- the freeze under a reserved size code;
- flag stickiness;
- the plain per-access step when wrapping is off.

Other behaviours are shown only by the directed scenarios:
- the wrapping arithmetic for several window sizes and for negative offsets;
- the order of combined strobes;
- the per-side minor-loop enables;
- the alignment decoding of the 16- and 32-byte codes.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

    localparam int unsigned SIZE_W = 3;
    localparam int unsigned MOD_W  = 5;
    localparam int unsigned NUM_LANES = 2;
    localparam int unsigned LANE_SRC = 0;
    localparam int unsigned LANE_DST = 1;

    typedef enum logic [SIZE_W-1:0] {
        ACC_1B  = 3'd0,
        ACC_2B  = 3'd1,
        ACC_4B  = 3'd2,
        ACC_16B = 3'd4,
        ACC_32B = 3'd5
    } acc_size_e;

    typedef struct packed {
        logic addr_bad;
        logic off_bad;
        logic cfg_bad;
    } lane_err_t;

    function automatic logic size_is_valid(input logic [SIZE_W-1:0] code);
        return (code == ACC_1B) || (code == ACC_2B) || (code == ACC_4B) ||
               (code == ACC_16B) || (code == ACC_32B);
    endfunction

    // Low-bit mask that must be zero for an aligned value of this size.
    function automatic logic [5:0] align_lsbs(input logic [SIZE_W-1:0] code);
        logic [5:0] m;
        case (code)
            ACC_2B:  m = 6'h01;
            ACC_4B:  m = 6'h03;
            ACC_16B: m = 6'h0F;
            ACC_32B: m = 6'h1F;
            default: m = 6'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_agen_align.sv
module dma_agen_align
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output lane_err_t         cur_err
);
    logic [5:0] lsbs;
    logic       valid;

    always_comb begin
        valid            = size_is_valid(size);
        lsbs             = align_lsbs(size);
        cur_err.cfg_bad  = !valid;
        cur_err.addr_bad = valid && ((addr[5:0] & lsbs) != 6'd0);
        cur_err.off_bad  = valid && ((off[5:0] & lsbs) != 6'd0);
    end
endmodule

// File: rtl/dma_agen_lane.sv
module dma_agen_lane
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned MLOFF_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  start,
    input  logic [OFF_W-1:0]   off,
    input  logic [SIZE_W-1:0]  size,
    input  logic [MOD_W-1:0]   modv,
    input  logic               step,
    input  logic               minor_go,
    input  logic [MLOFF_W-1:0] mloff,
    input  logic               major_go,
    input  logic [ADDR_W-1:0]  last,
    output logic [ADDR_W-1:0]  addr,
    output lane_err_t          err
);
    localparam int unsigned OFF_PAD = ADDR_W - OFF_W;
    localparam int unsigned ML_PAD  = ADDR_W - MLOFF_W;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] off_x, ml_x, wrap_mask, sum_off;
    logic [ADDR_W-1:0] after_off, after_ml, after_last;
    lane_err_t         err_q, cur_err;

    assign off_x = {{OFF_PAD{off[OFF_W-1]}}, off};
    assign ml_x  = {{ML_PAD{mloff[MLOFF_W-1]}}, mloff};

    // Bits inside the circular window take the new value.
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            wrap_mask[i] = (modv == '0) || (i < int'(modv));
        end
    end

    always_comb begin
        sum_off    = addr_q + off_x;
        after_off  = step ? ((addr_q & ~wrap_mask) | (sum_off & wrap_mask)) : addr_q;
        after_ml   = minor_go ? (after_off + ml_x) : after_off;
        after_last = major_go ? (after_ml + last) : after_ml;
    end

    dma_agen_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) align_i (
        .addr    (addr_q),
        .off     (off),
        .size    (size),
        .cur_err (cur_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            err_q  <= '0;
        end else if (load) begin
            addr_q <= start;
            err_q  <= '0;
        end else begin
            if (!cur_err.cfg_bad) begin
                addr_q <= after_last;
            end
            err_q <= err_q | cur_err;
        end
    end

    assign addr = addr_q;
    assign err  = err_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned MLOFF_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  src_start,
    input  logic [ADDR_W-1:0]  dst_start,
    input  logic [OFF_W-1:0]   src_off,
    input  logic [OFF_W-1:0]   dst_off,
    input  logic [2:0]         src_size,
    input  logic [2:0]         dst_size,
    input  logic [4:0]         src_mod,
    input  logic [4:0]         dst_mod,
    input  logic               mloff_src_en,
    input  logic               mloff_dst_en,
    input  logic [MLOFF_W-1:0] mloff,
    input  logic [ADDR_W-1:0]  src_last,
    input  logic [ADDR_W-1:0]  dst_last,
    input  logic               rd_done,
    input  logic               wr_done,
    input  logic               minor_done,
    input  logic               major_done,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr,
    output logic               src_addr_err,
    output logic               src_off_err,
    output logic               src_cfg_err,
    output logic               dst_addr_err,
    output logic               dst_off_err,
    output logic               dst_cfg_err
);
    logic [NUM_LANES-1:0][ADDR_W-1:0] l_start, l_last, l_addr;
    logic [NUM_LANES-1:0][OFF_W-1:0]  l_off;
    logic [NUM_LANES-1:0][SIZE_W-1:0] l_size;
    logic [NUM_LANES-1:0][MOD_W-1:0]  l_mod;
    logic [NUM_LANES-1:0]             l_step, l_minor;
    lane_err_t                        l_err [NUM_LANES];

    assign l_start[LANE_SRC] = src_start;
    assign l_start[LANE_DST] = dst_start;
    assign l_last[LANE_SRC]  = src_last;
    assign l_last[LANE_DST]  = dst_last;
    assign l_off[LANE_SRC]   = src_off;
    assign l_off[LANE_DST]   = dst_off;
    assign l_size[LANE_SRC]  = src_size;
    assign l_size[LANE_DST]  = dst_size;
    assign l_mod[LANE_SRC]   = src_mod;
    assign l_mod[LANE_DST]   = dst_mod;
    assign l_step[LANE_SRC]  = rd_done;
    assign l_step[LANE_DST]  = wr_done;
    assign l_minor[LANE_SRC] = minor_done && mloff_src_en;
    assign l_minor[LANE_DST] = minor_done && mloff_dst_en;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dma_agen_lane #(
            .ADDR_W (ADDR_W),
            .OFF_W  (OFF_W),
            .MLOFF_W(MLOFF_W)
        ) lane_i (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .start   (l_start[g]),
            .off     (l_off[g]),
            .size    (l_size[g]),
            .modv    (l_mod[g]),
            .step    (l_step[g]),
            .minor_go(l_minor[g]),
            .mloff   (mloff),
            .major_go(major_done),
            .last    (l_last[g]),
            .addr    (l_addr[g]),
            .err     (l_err[g])
        );
    end

    assign src_addr     = l_addr[LANE_SRC];
    assign dst_addr     = l_addr[LANE_DST];
    assign src_addr_err = l_err[LANE_SRC].addr_bad;
    assign src_off_err  = l_err[LANE_SRC].off_bad;
    assign src_cfg_err  = l_err[LANE_SRC].cfg_bad;
    assign dst_addr_err = l_err[LANE_DST].addr_bad;
    assign dst_off_err  = l_err[LANE_DST].off_bad;
    assign dst_cfg_err  = l_err[LANE_DST].cfg_bad;
endmodule

// File: rtl/dma_agen_sva.sv
module dma_agen_sva #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [ADDR_W-1:0] src_start,
    input logic [ADDR_W-1:0] dst_start,
    input logic [OFF_W-1:0]  src_off,
    input logic [2:0]        src_size,
    input logic [4:0]        src_mod,
    input logic              rd_done,
    input logic              wr_done,
    input logic              minor_done,
    input logic              major_done,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              src_addr_err,
    input logic              src_off_err,
    input logic              src_cfg_err,
    input logic              dst_addr_err,
    input logic              dst_off_err,
    input logic              dst_cfg_err
);
    logic src_reserved;
    assign src_reserved = (src_size == 3'd3) || (src_size == 3'd6) || (src_size == 3'd7);

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> (src_addr == $past(src_start)) && (dst_addr == $past(dst_start)));

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> !(src_addr_err || src_off_err || src_cfg_err ||
                   dst_addr_err || dst_off_err || dst_cfg_err));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !minor_done && !major_done && !load && src_mod == 5'd0 && !src_reserved)
        |=> src_addr == $past(src_addr + {{(ADDR_W-OFF_W){src_off[OFF_W-1]}}, src_off}));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (src_addr_err && !load) |=> src_addr_err);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (dst_off_err && !load) |=> dst_off_err);

    assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        (src_reserved && !load) |=> $stable(src_addr));

    assert_hold_src_R11: assert property (@(posedge clk) disable iff (rst)
        (!load && !rd_done && !minor_done && !major_done) |=> $stable(src_addr));

    assert_hold_dst_R11: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr_done && !minor_done && !major_done) |=> $stable(dst_addr));
endmodule

bind dma_addr_gen dma_agen_sva #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) sva_i (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .src_start   (src_start),
    .dst_start   (dst_start),
    .src_off     (src_off),
    .src_size    (src_size),
    .src_mod     (src_mod),
    .rd_done     (rd_done),
    .wr_done     (wr_done),
    .minor_done  (minor_done),
    .major_done  (major_done),
    .src_addr    (src_addr),
    .dst_addr    (dst_addr),
    .src_addr_err(src_addr_err),
    .src_off_err (src_off_err),
    .src_cfg_err (src_cfg_err),
    .dst_addr_err(dst_addr_err),
    .dst_off_err (dst_off_err),
    .dst_cfg_err (dst_cfg_err)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] src_start = '0, dst_start = '0, src_last = '0, dst_last = '0;
    logic [15:0] src_off = '0, dst_off = '0;
    logic [2:0]  src_size = 3'd0, dst_size = 3'd0;
    logic [4:0]  src_mod = '0, dst_mod = '0;
    logic        mloff_src_en = 1'b0, mloff_dst_en = 1'b0;
    logic [19:0] mloff = '0;
    logic        rd_done = 1'b0, wr_done = 1'b0, minor_done = 1'b0, major_done = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic        src_addr_err, src_off_err, src_cfg_err;
    logic        dst_addr_err, dst_off_err, dst_cfg_err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10ns clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst(rst), .load(load),
        .src_start(src_start), .dst_start(dst_start),
        .src_off(src_off), .dst_off(dst_off),
        .src_size(src_size), .dst_size(dst_size),
        .src_mod(src_mod), .dst_mod(dst_mod),
        .mloff_src_en(mloff_src_en), .mloff_dst_en(mloff_dst_en), .mloff(mloff),
        .src_last(src_last), .dst_last(dst_last),
        .rd_done(rd_done), .wr_done(wr_done),
        .minor_done(minor_done), .major_done(major_done),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .src_addr_err(src_addr_err), .src_off_err(src_off_err), .src_cfg_err(src_cfg_err),
        .dst_addr_err(dst_addr_err), .dst_off_err(dst_off_err), .dst_cfg_err(dst_cfg_err)
    );

    function automatic logic [31:0] wrap_ref(input logic [31:0] old, input logic [31:0] sum,
                                             input int n);
        longint unsigned win;
        if (n == 0) return sum;
        win = 64'd1 << n;
        return 32'(((64'(old) / win) * win) + (64'(sum) % win));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] s, input logic [31:0] d);
        src_start = s; dst_start = d; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic strobe(input logic r, input logic w, input logic mi, input logic ma);
        rd_done = r; wr_done = w; minor_done = mi; major_done = ma;
        @(negedge clk);
        rd_done = 0; wr_done = 0; minor_done = 0; major_done = 0;
    endtask

    task automatic t_reset();
        chk("R12 src_addr", src_addr, 32'h0);
        chk("R12 dst_addr", dst_addr, 32'h0);
        chk("R12 flags", 32'({src_addr_err, src_off_err, src_cfg_err,
                              dst_addr_err, dst_off_err, dst_cfg_err}), 32'h0);
    endtask

    task automatic t_basic_step();
        src_size = 3'd2; dst_size = 3'd2; src_off = 16'd4; dst_off = 16'hFFF8;
        do_load(32'h1000, 32'h2000);
        chk("R1 src load", src_addr, 32'h1000);
        chk("R1 dst load", dst_addr, 32'h2000);
        for (int i = 0; i < 3; i++) strobe(1, 0, 0, 0);
        chk("R2 src +4 x3", src_addr, 32'h100C);
        chk("R2 dst untouched by read", dst_addr, 32'h2000);
        for (int i = 0; i < 2; i++) strobe(0, 1, 0, 0);
        chk("R2 dst -8 x2", dst_addr, 32'h1FF0);
        chk("R2 src untouched by write", src_addr, 32'h100C);
        repeat (3) @(negedge clk);
        chk("R11 idle src hold", src_addr, 32'h100C);
        chk("R11 idle dst hold", dst_addr, 32'h1FF0);
    endtask

    task automatic t_modulo();
        src_size = 3'd2; src_off = 16'd4; src_mod = 5'd4;
        dst_size = 3'd2; dst_off = 16'hFFF8; dst_mod = 5'd3;
        do_load(32'h3F8, 32'h2004);
        strobe(1, 1, 0, 0);
        chk("R4 src wrap step1", src_addr, wrap_ref(32'h3F8, 32'h3FC, 4));
        chk("R4 dst wrap negative", dst_addr, wrap_ref(32'h2004, 32'h1FFC, 3));
        strobe(1, 0, 0, 0);
        chk("R4 src wrap across window", src_addr, 32'h3F0);
        src_mod = 5'd0; dst_mod = 5'd0;
    endtask

    task automatic t_minor();
        src_size = 3'd2; dst_size = 3'd2;
        mloff = 20'hFFFF0; mloff_src_en = 1'b1; mloff_dst_en = 1'b0;
        do_load(32'h4000, 32'h5000);
        strobe(0, 0, 1, 0);
        chk("R5 src minor -0x10", src_addr, 32'h3FF0);
        chk("R5 dst disabled", dst_addr, 32'h5000);
        mloff_src_en = 1'b0; mloff_dst_en = 1'b1; mloff = 20'h00100;
        strobe(0, 0, 1, 0);
        chk("R5 dst minor +0x100", dst_addr, 32'h5100);
        chk("R5 src disabled", src_addr, 32'h3FF0);
        mloff_dst_en = 1'b0;
    endtask

    task automatic t_major();
        src_last = 32'hFFFF_FF00; dst_last = 32'h0000_0040;
        do_load(32'h6000, 32'h7000);
        strobe(0, 0, 0, 1);
        chk("R6 src last", src_addr, 32'h5F00);
        chk("R6 dst last", dst_addr, 32'h7040);
        src_last = '0; dst_last = '0;
    endtask

    task automatic t_order();
        src_size = 3'd2; src_off = 16'd4; src_mod = 5'd3;
        mloff = 20'h00040; mloff_src_en = 1'b1; src_last = 32'h1000;
        do_load(32'h100, 32'h800);
        strobe(1, 0, 0, 0);
        chk("R4 src wrap 8B", src_addr, 32'h104);
        strobe(1, 0, 1, 1);
        chk("R7 combined order", src_addr, 32'h1140);
        chk("R7 dst with zero last", dst_addr, 32'h800);
        src_mod = '0; mloff_src_en = 1'b0; src_last = '0;
    endtask

    task automatic t_align();
        src_size = 3'd2; src_off = 16'd4; dst_size = 3'd2; dst_off = 16'd6;
        do_load(32'h1002, 32'h2000);
        chk("R1 flags clear on load", 32'({src_addr_err, dst_off_err}), 32'h0);
        @(negedge clk);
        chk("R8 src addr misaligned", 32'(src_addr_err), 32'h1);
        chk("R9 src offset aligned", 32'(src_off_err), 32'h0);
        chk("R9 dst offset misaligned", 32'(dst_off_err), 32'h1);
        chk("R8 dst addr aligned", 32'(dst_addr_err), 32'h0);
        dst_off = 16'd4;
        repeat (2) @(negedge clk);
        chk("R9 sticky", 32'(dst_off_err), 32'h1);
        do_load(32'h1000, 32'h2000);
        chk("R1 clear after errors", 32'({src_addr_err, dst_off_err}), 32'h0);
        // Large sizes: 16-byte src at 0x1008 is bad, 32-byte dst at 0x2000 is fine
        src_size = 3'd4; src_off = 16'h10; dst_size = 3'd5; dst_off = 16'h20;
        do_load(32'h1008, 32'h2000);
        strobe(0, 1, 0, 0);
        chk("R3 16B misaligned", 32'(src_addr_err), 32'h1);
        chk("R3 16B offset ok", 32'(src_off_err), 32'h0);
        chk("R3 32B step", dst_addr, 32'h2020);
        chk("R3 32B no error", 32'({dst_addr_err, dst_off_err}), 32'h0);
    endtask

    task automatic t_reserved();
        src_size = 3'd3; src_off = 16'd4; dst_size = 3'd2; dst_off = 16'd4;
        mloff = 20'h00010; mloff_src_en = 1'b1; src_last = 32'h100;
        do_load(32'h500, 32'h600);
        strobe(1, 1, 1, 1);
        chk("R10 src frozen", src_addr, 32'h500);
        chk("R10 src cfg flag", 32'(src_cfg_err), 32'h1);
        chk("R10 dst still steps", dst_addr, 32'h604);
        chk("R10 dst cfg clear", 32'(dst_cfg_err), 32'h0);
        src_size = 3'd7;
        strobe(1, 0, 0, 0);
        chk("R10 code 7 frozen", src_addr, 32'h500);
        mloff_src_en = 1'b0; src_last = '0; src_size = 3'd2;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic_step();
        t_modulo();
        t_minor();
        t_major();
        t_order();
        t_align();
        t_reserved();
        done_flag = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end
endmodule